// File: doc/BRIEF.md
# Quad I/O Execute-in-Place Read Engine

This block turns word read requests into quad-wire reads from a serial NOR flash. A requester asserts `req` with a byte address while `ready` is high. Some time later the block returns one 32-bit word on `rd_data` with a single-cycle `rd_valid` pulse. On the flash side it drives the serial clock, the active-low chip select and four data wires. Each of the four wires has its own output enable.

The first request after reset, or after an exit, starts with a priming transaction. Priming sends the fast-quad-read instruction on one wire, then an address/mode frame on all four wires. The mode byte leaves the flash in continuous-read mode. The engine then raises chip select and runs the fetch for the request.

Every later fetch skips the instruction. It sends only the 24-bit address and the mode byte in quad, releases the wires for the dummy cycles, and then collects eight data nibbles. An exit input sends one frame with a neutral mode byte, which takes the flash out of continuous-read mode. The next request then primes the flash again.

Top module: `quad_xip_fetch`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, `io_oe` is 0000, `rd_valid` is 0 and `ready` is 1.
- R2: The first accepted request after reset or after an exit first runs a priming transaction. The byte 0xEB is sent most significant bit first on wire 0 with `io_oe` = 0001. Then the frame 0x000000A0 (address 0, mode 0xA0) is sent on all four wires with `io_oe` = 1111. Chip select rises after exactly 16 rising serial clock edges and no data is received. The fetch for the request follows.
- R3: A fetch sends no instruction. Its frame is {addr[23:0], 8'hA0}, sent most significant nibble first. addr[31:24] has no effect on the frame or on the data.
- R4: After the frame, a fetch releases all four wires for exactly 4 serial clocks while the clock keeps toggling. It then receives 8 nibbles, for 20 rising edges per fetch. The engine never drives a wire while the flash drives it.
- R5: Each received byte arrives high nibble first. The word is little-endian: the byte at the requested address goes in `rd_data[7:0]`. Each nibble is sampled RX_DLY system clocks after the rising serial edge. `rd_valid` is high for exactly one cycle per fetch.
- R6: With the defaults (HALF=2), `rd_valid` rises 80 clock edges after the accepting edge when the flash is already primed, and 148 edges after it when priming is needed.
- R7: `sclk` is low whenever `cs_n` is high. Between two transactions, `cs_n` stays high for at least 2*HALF clocks, which is one serial clock period.
- R8: The serial clock idles low. `io_out` and `io_oe` change only while `sclk` is low (mode 0).
- R9: An idle, primed engine given `exit_req` sends one frame 0x00000000 (mode 0x00) in 8 edges and produces no `rd_valid`. The next request primes again. `exit_req` does nothing when the engine is not primed. It takes priority over a `req` in the same cycle, and that `req` is dropped.
- R10: `ready` is high only when the engine is idle. A `req` while `ready` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Read request, taken when `ready` is high |
| addr | input | 32 | Request address; bits [23:0] select the flash byte |
| exit_req | input | 1 | Leave continuous-read mode |
| ready | output | 1 | Engine idle, request can be taken |
| rd_data | output | 32 | Fetched word, little-endian |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| sclk | output | 1 | Serial clock to the flash |
| cs_n | output | 1 | Chip select to the flash, active low |
| io_out | output | 4 | Values driven on the four data wires |
| io_oe | output | 4 | Per-wire output enable |
| io_in | input | 4 | Values read from the four data wires |

## Verification
A primed fetch must produce `rd_valid` 80 clock edges after the accepting edge. A fetch that includes priming must produce it 148 edges after. The bench counts falling clock edges from the accepting edge, takes the first one with `rd_valid` high, and compares that count with the figure due. It compares the word at that same falling edge.

Frame contents, edge counts and instruction capture come from a behavioural flash model in the bench. These are checked only after `ready` returns, when chip select is high and the transaction record is final.

Exit and ignored-request cases are checked by comparing transaction and `rd_valid` counts before and after the stimulus.

// File: rtl/quad_xip_fetch.sv
module quad_xip_fetch #(
  parameter int HALF = 2,
  parameter int RX_DLY = 1,
  parameter int WAIT_CLKS = 4,
  parameter logic [7:0] MODE = 8'hA0,
  parameter logic [7:0] CMD = 8'hEB
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [31:0] addr,
  input  logic        exit_req,
  output logic        ready,
  output logic [31:0] rd_data,
  output logic        rd_valid,
  output logic        sclk,
  output logic        cs_n,
  output logic [3:0]  io_out,
  output logic [3:0]  io_oe,
  input  logic [3:0]  io_in
);
  localparam int CW = $clog2(2 * HALF);
  localparam logic [CW-1:0] LAST = CW'(2 * HALF - 1);
  localparam logic [CW-1:0] HI   = CW'(HALF);
  localparam logic [CW-1:0] SAMP = CW'(HALF + RX_DLY - 1);
  localparam logic [7:0]    WEND = 8'(WAIT_CLKS - 1);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_ADR, S_WAIT, S_DAT, S_GAP} state_t;
  typedef enum logic [1:0] {K_PRIME, K_FETCH, K_EXIT} kind_t;

  state_t        state;
  kind_t         kind;
  logic [CW-1:0] cnt;
  logic [7:0]    bits;
  logic [31:0]   tx;
  logic [31:0]   rx;
  logic [23:0]   fa;
  logic          primed;

  assign ready  = (state == S_IDLE);
  assign cs_n   = (state == S_IDLE) || (state == S_GAP);
  assign sclk   = !cs_n && (cnt >= HI);
  assign io_oe  = (state == S_CMD) ? 4'b0001 : (state == S_ADR) ? 4'b1111 : 4'b0000;
  assign io_out = (state == S_CMD) ? {3'b000, tx[31]} : (state == S_ADR) ? tx[31:28] : 4'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      kind     <= K_FETCH;
      cnt      <= '0;
      bits     <= '0;
      tx       <= '0;
      rx       <= '0;
      fa       <= '0;
      primed   <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (state == S_IDLE) begin
        cnt  <= '0;
        bits <= '0;
        if (exit_req && primed) begin
          kind  <= K_EXIT;
          tx    <= 32'h0;
          state <= S_ADR;
        end else if (req) begin
          fa <= addr[23:0];
          if (primed) begin
            kind  <= K_FETCH;
            tx    <= {addr[23:0], MODE};
            state <= S_ADR;
          end else begin
            kind  <= K_PRIME;
            tx    <= {CMD, 24'h0};
            state <= S_CMD;
          end
        end
      end else begin
        cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
        if (state == S_DAT && cnt == SAMP) rx <= {rx[27:0], io_in};
        if (cnt == LAST) begin
          bits <= bits + 8'd1;
          case (state)
            S_CMD: begin
              if (bits == 8'd7) begin
                state <= S_ADR;
                bits  <= '0;
                tx    <= {24'h0, MODE};
              end else tx <= {tx[30:0], 1'b0};
            end
            S_ADR: begin
              if (bits == 8'd7) begin
                bits <= '0;
                if (kind == K_FETCH) state <= S_WAIT;
                else begin
                  state  <= S_GAP;
                  primed <= (kind == K_PRIME);
                end
              end else tx <= {tx[27:0], 4'h0};
            end
            S_WAIT: begin
              if (bits == WEND) begin
                state <= S_DAT;
                bits  <= '0;
              end
            end
            S_DAT: begin
              if (bits == 8'd7) begin
                state    <= S_GAP;
                bits     <= '0;
                rd_valid <= 1'b1;
                rd_data  <= {rx[7:0], rx[15:8], rx[23:16], rx[31:24]};
              end
            end
            S_GAP: begin
              bits <= '0;
              if (kind == K_PRIME) begin
                kind  <= K_FETCH;
                tx    <= {fa, MODE};
                state <= S_ADR;
              end else state <= S_IDLE;
            end
            default: state <= S_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/xip_fetch_chk.sv
module xip_fetch_chk #(
  parameter int HALF = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sclk,
  input logic [3:0] io_oe,
  input logic [3:0] io_out,
  input logic       rd_valid,
  input logic       ready
);
  localparam logic [7:0] GAPMIN = 8'(2 * HALF);
  logic [7:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap <= 8'd0;
    else if (cs_n) gap <= (gap == 8'hFF) ? gap : gap + 8'd1;
    else gap <= 8'd0;
  end

  assert_clock_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  assert_deselect_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (gap >= GAPMIN));
  assert_mode0_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> ($stable(io_out) && $stable(io_oe)));
  assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  assert_busy_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> !ready);
  assert_released_when_deselected_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (io_oe == 4'b0000));
  assert_legal_enables_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_oe == 4'b0000) || (io_oe == 4'b0001) || (io_oe == 4'b1111));
endmodule

bind quad_xip_fetch xip_fetch_chk #(.HALF(HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .io_oe(io_oe),
  .io_out(io_out), .rd_valid(rd_valid), .ready(ready)
);

// File: tb/quad_xip_fetch_bench.sv
module quad_xip_fetch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [31:0] addr = '0;
  logic        exit_req = 1'b0;
  logic        ready, rd_valid, sclk, cs_n;
  logic [31:0] rd_data;
  logic [3:0]  io_out, io_oe, io_in;

  int nvec = 0, nfail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  quad_xip_fetch u_quad_xip_fetch (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .exit_req(exit_req),
    .ready(ready), .rd_data(rd_data), .rd_valid(rd_valid), .sclk(sclk),
    .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  function automatic logic [7:0] mb(logic [23:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ {a[22:16], a[23]} ^ 8'hC3;
  endfunction

  function automatic logic [31:0] exp_word(logic [23:0] a);
    return {mb(a + 24'd3), mb(a + 24'd2), mb(a + 24'd1), mb(a)};
  endfunction

  // behavioural flash
  int pcnt = 0, n_trans = 0, n_cmd = 0, last_edges = 0, prime_edges = 0;
  bit skip = 0, fcont = 0, last_had_cmd = 0;
  logic [7:0] fcmd = '0, prime_cmd = '0;
  logic [31:0] fadr = '0, last_frame = '0, prime_frame = '0;
  logic [3:0] fdrv = '0;
  logic fdrv_en = 1'b0;

  assign io_in = (fdrv_en && !cs_n) ? fdrv : 4'h0;

  always @(posedge sclk) begin
    int idx;
    if (!cs_n) begin
      if (pcnt == 0) begin skip = fcont; fcmd = '0; fadr = '0; fdrv_en = 1'b0; end
      idx = skip ? pcnt + 8 : pcnt;
      if (idx < 8) fcmd = {fcmd[6:0], io_out[0]};
      else if (idx < 16) begin
        fadr = {fadr[27:0], io_out};
        if (idx == 15) fcont = (skip || fcmd == 8'hEB) && (fadr[5:4] == 2'b10);
      end
      pcnt++;
    end
  end

  always @(negedge sclk) begin
    int idx, nib;
    logic [7:0] b;
    if (cs_n === 1'b0) begin
      idx = skip ? pcnt + 8 : pcnt;
      if (idx >= 20) begin
        nib = idx - 20;
        b = mb(fadr[31:8] + 24'(nib / 2));
        fdrv = (nib % 2 == 0) ? b[7:4] : b[3:0];
        fdrv_en = 1'b1;
      end
    end
  end

  always @(posedge cs_n) begin
    if (pcnt > 0) begin
      n_trans++;
      last_edges = pcnt;
      last_frame = fadr;
      last_had_cmd = !skip;
      if (!skip) begin
        n_cmd++;
        prime_cmd = fcmd;
        prime_frame = fadr;
        prime_edges = pcnt;
      end
    end
    pcnt = 0;
    fdrv_en = 1'b0;
  end

  // port monitors
  int n_valid = 0, clash = 0, v7 = 0, v8 = 0, hi_run = 0;
  logic p_sclk = 1'b0;
  logic [3:0] p_out = '0, p_oe = '0;
  always @(negedge clk) if (rst_n) begin
    if (rd_valid) n_valid++;
    if (fdrv_en && !cs_n && io_oe != 4'b0000) clash++;
    if (cs_n && sclk) v7++;
    if (cs_n) hi_run++;
    else begin
      if (hi_run > 0 && hi_run < 4) v7++;
      hi_run = 0;
    end
    if (p_sclk && sclk && (io_out != p_out || io_oe != p_oe)) v8++;
    p_sclk = sclk; p_out = io_out; p_oe = io_oe;
  end

  task automatic check(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic wait_ready();
    while (!ready) @(negedge clk);
  endtask

  bit primed_m = 0;

  task automatic fetch(logic [31:0] a);
    int n;
    bit needp;
    int cmd0;
    needp = !primed_m;
    cmd0 = n_cmd;
    wait_ready();
    req = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk); req = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!rd_valid && n < 400);
    check(n == (needp ? 148 : 80), "R6", 32'(n), needp ? 32'd148 : 32'd80);
    check(rd_data == exp_word(a[23:0]), "R5", rd_data, exp_word(a[23:0]));
    wait_ready();
    check(last_frame == {a[23:0], 8'hA0} && !last_had_cmd, "R3", last_frame, {a[23:0], 8'hA0});
    check(last_edges == 20, "R4", 32'(last_edges), 32'd20);
    if (needp) begin
      check(n_cmd == cmd0 + 1 && prime_cmd == 8'hEB, "R2", {24'h0, prime_cmd}, 32'hEB);
      check(prime_frame == 32'h000000A0 && prime_edges == 16, "R2",
            prime_frame ^ 32'(prime_edges), 32'hA0 ^ 32'd16);
    end
    primed_m = 1;
  endtask

  task automatic do_exit();
    int t0, v0;
    wait_ready();
    t0 = n_trans; v0 = n_valid;
    exit_req = 1'b1;
    @(posedge clk);
    @(negedge clk); exit_req = 1'b0;
    repeat (60) @(negedge clk);
    wait_ready();
    if (primed_m) begin
      check(n_trans == t0 + 1 && last_frame == 32'h0 && last_edges == 8, "R9",
            last_frame | 32'(last_edges), 32'd8);
    end else begin
      check(n_trans == t0, "R9", 32'(n_trans), 32'(t0));
    end
    check(n_valid == v0, "R9", 32'(n_valid), 32'(v0));
    primed_m = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(cs_n == 1'b1 && sclk == 1'b0 && io_oe == 4'h0 && rd_valid == 1'b0 && ready == 1'b1,
          "R1", {27'h0, cs_n, sclk, rd_valid, ready, |io_oe}, 32'b10010);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R9: exit ignored while not primed
    do_exit();
    // R2/R6: first request primes
    fetch(32'h1000_0040);
    // R3: upper address bits ignored
    fetch(32'h7F00_0040);
    fetch(32'h1000_0000);
    // R5: 24-bit wraparound
    fetch(32'h10FF_FFFE);

    // R10: request while busy is ignored
    begin
      int v0, t0;
      wait_ready();
      v0 = n_valid; t0 = n_trans;
      req = 1'b1; addr = 32'h1000_1234;
      @(posedge clk);
      @(negedge clk); req = 1'b0;
      repeat (10) @(negedge clk);
      check(ready == 1'b0, "R10", 32'(ready), 32'd0);
      req = 1'b1; addr = 32'h1000_5678;
      @(negedge clk); req = 1'b0;
      wait_ready();
      repeat (30) @(negedge clk);
      check(n_valid == v0 + 1 && n_trans == t0 + 1, "R10", 32'(n_valid - v0), 32'd1);
      check(rd_data == exp_word(24'h001234), "R10", rd_data, exp_word(24'h001234));
    end

    // R9: exit then re-prime
    do_exit();
    fetch(32'h1012_3456);

    // R9: exit wins over simultaneous request
    begin
      int v0;
      wait_ready();
      v0 = n_valid;
      exit_req = 1'b1; req = 1'b1; addr = 32'h1000_0100;
      @(posedge clk);
      @(negedge clk); exit_req = 1'b0; req = 1'b0;
      repeat (80) @(negedge clk);
      check(n_valid == v0 && last_frame == 32'h0, "R9", last_frame, 32'h0);
      primed_m = 0;
    end
    fetch(32'h1000_0100);

    // random traffic
    for (int i = 0; i < 40; i++) begin
      int r;
      r = int'($urandom % 8);
      if (r == 0) do_exit();
      else fetch($urandom);
      repeat (int'($urandom % 6)) @(negedge clk);
    end

    check(clash == 0, "R4", 32'(clash), 32'd0);
    check(v7 == 0, "R7", 32'(v7), 32'd0);
    check(v8 == 0, "R8", 32'(v8), 32'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule